// File: doc/BRIEF.md
# Packet Set Delivery Sequencer

This block decides which core gets the shared test bus next while a group of cores is tested together. The group holds three kinds of core, by how many packets each gets in one packet set. There are k cores that get one packet, nr = d·k/r cores that get r packets, and q cores that get 2k packets. A packet set is a list of 2k rows, issued in order from the first row to the last and left to right within each row.

Odd-numbered rows (first, third, ...) carry one packet for every 2k-packet core, then d packets for the r-packet cores. Each of these d picks takes the next r-packet core in turn, and the turn carries over from one odd row to the next. Even-numbered rows carry one packet for every 2k-packet core, then one packet for the next 1-packet core.

Each slot names a core and a packet number. The slot asks for the test vector packet to be written, then for the response packet to be read. A one-cycle transfer-complete pulse ends each of the two phases. The set is repeated the number of times configured at start, and then the block raises a done flag.

Top module: `pkt_set_seq`

## Requirements
- R1: While reset is held and right after it, `vec_req`, `rsp_req` and `done` are 0, and `core_idx` and `pkt_num` are 0.
- R2: A slot first holds `vec_req` high until a `xfer_done` pulse. In the next cycle it holds `rsp_req` high, with the same `core_idx` and `pkt_num`, until a second pulse. The cycle after that second pulse shows the next slot's `vec_req`.
- R3: Every row begins with the q 2k-packet cores. These have core indices 0 to q-1 and are issued in ascending order.
- R4: An even-numbered row (2nd, 4th, ...) ends with exactly one 1-packet core. Row 2m uses core index q+m-1, so the 1-packet cores, indices q to q+k-1, appear in ascending order across the set.
- R5: The packet number of a 2k-packet core equals the 1-based row number, so it runs from 1 to 2k within a set.
- R6: An odd-numbered row ends with d slots for the r-packet cores. These have indices q+k to q+k+nr-1, where nr = d·k/r. They are picked in rotating ascending order that continues across odd rows. The packet number is 1 on the first pass through them, 2 on the second, and so on up to r, so each gets r packets per set.
- R7: A 1-packet core always carries packet number 1.
- R8: The packet set is issued `cfg_sets` times, each identical. After the final response phase, `done` goes to 1 and no further request appears until the next `start`.
- R9: A `start` with `cfg_k` = 0 or `cfg_sets` = 0 raises `done` the next cycle and issues no slot.
- R10: A `start` pulse while a slot is in progress has no effect on the sequence.
- R11: When q = 0 and d = 0, the empty odd rows are skipped, and the schedule consists only of the 1-packet slots.
- R12: Configuration is captured on an accepted `start`. Later changes to the `cfg_*` inputs have no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; accepted when idle or done |
| cfg_k | input | CW | Number of 1-packet cores (k) |
| cfg_q | input | CW | Number of 2k-packet cores (q) |
| cfg_d | input | CW | r-packet slots per odd row (d) |
| cfg_r | input | CW | Packets per set for each r-packet core (r) |
| cfg_sets | input | SETW | Number of packet sets to issue |
| xfer_done | input | 1 | One-cycle pulse ending the current phase |
| vec_req | output | 1 | Request to write the test vector packet |
| rsp_req | output | 1 | Request to read the response packet |
| core_idx | output | 2*CW+1 | Core selected by the current slot |
| pkt_num | output | CW+1 | 1-based packet number for that core |
| done | output | 1 | All configured sets issued |

## Verification
On every cycle the assertions check four things. The vector phase always hands over to the response phase, and the slot identity holds steady through it. The position within a row never passes the row length. The rotating pointer and pass count for the r-packet cores stay inside their configured range, and done holds until a new start.

Some properties only show in the bench's scenarios, which compare the full slot sequence against a reference list. These are the exact order of rows and slots, the packet numbers, identical repetition of sets, and the skipping of empty odd rows. The same holds for the immunity of a run to a mid-run start or to configuration changes.

// File: rtl/pkt_set_seq_pkg.sv
// Shared types for the packet set delivery sequencer.
package pkt_set_seq_pkg;

    // Handshake phase of the sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VEC  = 2'd1,
        ST_RSP  = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

    // Which class of core the current slot belongs to.
    typedef enum logic [1:0] {
        KIND_2K = 2'd0,
        KIND_R  = 2'd1,
        KIND_1  = 2'd2
    } slot_kind_e;

endpackage

// File: rtl/pss_slot_fsm.sv
// Slot handshake controller.
// Does: runs the vector-write then response-read phases of each slot and
//       decides when the run is finished.
// Assumes: xfer_done is a one-cycle pulse per phase; last_slot is valid
//          whenever the response phase is active.
module pss_slot_fsm
    import pkt_set_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       empty_cfg,
    input  logic       xfer_done,
    input  logic       last_slot,
    output seq_state_e state,
    output logic       load,
    output logic       adv
);

    seq_state_e state_nx;

    // Accept a start only outside a run; advance after each response phase.
    always_comb begin
        load = start && (state == ST_IDLE || state == ST_DONE);
        adv  = (state == ST_RSP) && xfer_done;
    end

    // Next-state selection for the two-phase slot handshake.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE, ST_DONE: if (load) state_nx = empty_cfg ? ST_DONE : ST_VEC;
            ST_VEC:           if (xfer_done) state_nx = ST_RSP;
            ST_RSP:           if (xfer_done) state_nx = last_slot ? ST_DONE : ST_VEC;
            default:          state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R2: a completed vector phase is always followed by the response phase.
    a_r2_vec_to_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VEC && xfer_done) |=> (state == ST_RSP));

    // R8: done holds until a new start arrives.
    a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !start) |=> (state == ST_DONE));

    // R10: a start during a response phase does not leave the phase.
    a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RSP && !xfer_done) |=> (state == ST_RSP));

endmodule

// File: rtl/pss_row_walker.sv
// Row and position walker.
// Does: steps through rows and slot positions of the packet set, counts
//       sets, classifies the current slot and flags the run's final slot.
// Assumes: configuration is stable between loads; k >= 1 during a run.
module pss_row_walker
    import pkt_set_seq_pkg::*;
#(
    parameter int CW   = 4,
    parameter int SETW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            init_skip,
    input  logic            adv,
    input  logic            active,
    input  logic [CW-1:0]   k,
    input  logic [CW-1:0]   q,
    input  logic [CW-1:0]   d,
    input  logic [SETW-1:0] sets,
    output logic [CW:0]     row,
    output logic [CW:0]     pos,
    output slot_kind_e      kind,
    output logic            set_wrap,
    output logic            last_slot
);

    localparam int RW = CW + 1;

    logic [SETW-1:0] set_cnt;
    logic [CW:0]     row_len;
    logic [RW-1:0]   last_row_idx;
    logic            odd_row, odd_empty, last_in_row, last_row, last_set;

    // Row geometry and end-of-row, end-of-set, end-of-run decode.
    always_comb begin
        odd_row      = ~row[0];
        odd_empty    = (q == '0) && (d == '0);
        row_len      = odd_row ? ({1'b0, q} + {1'b0, d}) : ({1'b0, q} + (CW+1)'(1));
        last_in_row  = (pos == row_len - (CW+1)'(1));
        last_row_idx = {k, 1'b0} - RW'(1);
        last_row     = (row == last_row_idx);
        last_set     = (set_cnt == sets - SETW'(1));
        last_slot    = last_in_row && last_row && last_set;
        set_wrap     = adv && last_in_row && last_row;
    end

    // Slot class from the position in the row.
    always_comb begin
        if (pos < {1'b0, q}) kind = KIND_2K;
        else if (odd_row)    kind = KIND_R;
        else                 kind = KIND_1;
    end

    // Row, position and set counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row     <= '0;
            pos     <= '0;
            set_cnt <= '0;
        end else if (load) begin
            row     <= init_skip ? RW'(1) : '0;
            pos     <= '0;
            set_cnt <= '0;
        end else if (adv) begin
            if (!last_in_row) begin
                pos <= pos + (CW+1)'(1);
            end else begin
                pos <= '0;
                if (last_row) begin
                    if (!last_set) begin
                        set_cnt <= set_cnt + SETW'(1);
                        row     <= odd_empty ? RW'(1) : '0;
                    end
                end else if (row[0] && odd_empty) begin
                    row <= row + RW'(2);
                end else begin
                    row <= row + RW'(1);
                end
            end
        end
    end

    // R3: the slot position never runs past the end of its row.
    a_r3_pos_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (pos < row_len));

    // R8: the set counter stays below the configured number of sets.
    a_r8_set_range: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (set_cnt < sets));

endmodule

// File: rtl/pss_rotor.sv
// Rotating selector for the r-packet cores.
// Does: keeps the next r-packet core to serve and how many full passes
//       over those cores have been made in the current set.
// Assumes: clear arrives at each set boundary; nr = d*k/r exactly.
module pss_rotor #(
    parameter int CW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            clear,
    input  logic            step,
    input  logic [2*CW-1:0] nr,
    input  logic [CW-1:0]   r,
    output logic [2*CW-1:0] ptr,
    output logic [CW:0]     pass
);

    localparam int NW = 2 * CW;

    logic wrap;

    // The pointer wraps after the last r-packet core.
    always_comb wrap = (ptr + NW'(1)) >= nr;

    // Pointer and pass counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            pass <= '0;
        end else if (load || clear) begin
            ptr  <= '0;
            pass <= '0;
        end else if (step) begin
            if (wrap) begin
                ptr  <= '0;
                pass <= pass + (CW+1)'(1);
            end else begin
                ptr <= ptr + NW'(1);
            end
        end
    end

    // R6: the pointer always addresses an existing r-packet core.
    a_r6_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (nr != '0) |-> (ptr < nr));

    // R6: no r-packet core gets more than r packets in one set.
    a_r6_pass_range: assert property (@(posedge clk) disable iff (!rst_n)
        (nr != '0) |-> (pass <= {1'b0, r}));

endmodule

// File: rtl/pkt_set_seq.sv
// Packet set delivery sequencer (top).
// Does: latches the group configuration on start, then issues every slot of
//       the interleaved packet set, repeated the configured number of times.
//       Each slot names a core and a packet number and runs a vector-write
//       phase and then a response-read phase.
// Assumes: d*k is a multiple of r; core indices are laid out as 2k-packet
//          cores, then 1-packet cores, then r-packet cores.
module pkt_set_seq
    import pkt_set_seq_pkg::*;
#(
    parameter int CW   = 4,
    parameter int SETW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CW-1:0]       cfg_k,
    input  logic [CW-1:0]       cfg_q,
    input  logic [CW-1:0]       cfg_d,
    input  logic [CW-1:0]       cfg_r,
    input  logic [SETW-1:0]     cfg_sets,
    input  logic                xfer_done,
    output logic                vec_req,
    output logic                rsp_req,
    output logic [2*CW:0]       core_idx,
    output logic [CW:0]         pkt_num,
    output logic                done
);

    localparam int NW = 2 * CW;
    localparam int IW = 2 * CW + 1;
    localparam int PW = CW + 1;

    seq_state_e      state;
    slot_kind_e      kind;
    logic            load, adv, active, set_wrap, last_slot, empty_cfg, init_skip;
    logic [CW-1:0]   lk, lq, ld, lr;
    logic [SETW-1:0] lsets;
    logic [NW-1:0]   lnr, nr_calc, prod;
    logic [CW:0]     row, pos, pass;
    logic [NW-1:0]   ptr;

    // Decode of the raw configuration at the start request.
    always_comb begin
        prod      = NW'(cfg_d) * NW'(cfg_k);
        nr_calc   = (cfg_r == '0) ? '0 : prod / NW'(cfg_r);
        empty_cfg = (cfg_k == '0) || (cfg_sets == '0);
        init_skip = (cfg_q == '0) && (cfg_d == '0);
    end

    // Configuration capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk <= '0; lq <= '0; ld <= '0; lr <= '0; lsets <= '0; lnr <= '0;
        end else if (load) begin
            lk <= cfg_k; lq <= cfg_q; ld <= cfg_d; lr <= cfg_r;
            lsets <= cfg_sets; lnr <= nr_calc;
        end
    end

    pss_slot_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .empty_cfg (empty_cfg),
        .xfer_done (xfer_done),
        .last_slot (last_slot),
        .state     (state),
        .load      (load),
        .adv       (adv)
    );

    pss_row_walker #(.CW(CW), .SETW(SETW)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .init_skip (init_skip),
        .adv       (adv),
        .active    (active),
        .k         (lk),
        .q         (lq),
        .d         (ld),
        .sets      (lsets),
        .row       (row),
        .pos       (pos),
        .kind      (kind),
        .set_wrap  (set_wrap),
        .last_slot (last_slot)
    );

    pss_rotor #(.CW(CW)) u_rot (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .clear (set_wrap),
        .step  (adv && (kind == KIND_R)),
        .nr    (lnr),
        .r     (lr),
        .ptr   (ptr),
        .pass  (pass)
    );

    // Phase outputs from the handshake state.
    always_comb begin
        vec_req = (state == ST_VEC);
        rsp_req = (state == ST_RSP);
        done    = (state == ST_DONE);
        active  = vec_req || rsp_req;
    end

    // Core index and packet number of the current slot.
    always_comb begin
        core_idx = '0;
        pkt_num  = '0;
        if (active) begin
            case (kind)
                KIND_2K: begin
                    core_idx = IW'(pos);
                    pkt_num  = PW'(row) + PW'(1);
                end
                KIND_R: begin
                    core_idx = IW'(lq) + IW'(lk) + IW'(ptr);
                    pkt_num  = pass + PW'(1);
                end
                default: begin
                    core_idx = IW'(lq) + IW'(row >> 1);
                    pkt_num  = PW'(1);
                end
            endcase
        end
    end

    // R2: slot identity is unchanged through the response phase.
    a_r2_slot_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_req |-> ($stable(core_idx) && $stable(pkt_num)));

    // R5: an issued slot always carries a nonzero packet number.
    a_r5_pkt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> (pkt_num != '0));

endmodule

// File: tb/sim_pkt_set_seq.sv
module sim_pkt_set_seq;
    localparam int CW   = 4;
    localparam int SETW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CW-1:0]     cfg_k = '0, cfg_q = '0, cfg_d = '0, cfg_r = '0;
    logic [SETW-1:0]   cfg_sets = '0;
    logic              xfer_done = 1'b0;
    logic              vec_req, rsp_req, done;
    logic [2*CW:0]     core_idx;
    logic [CW:0]       pkt_num;

    int checks = 0;
    int errors = 0;
    int exp_core[$];
    int exp_pkt[$];
    string exp_tag[$];

    pkt_set_seq #(.CW(CW), .SETW(SETW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_k(cfg_k), .cfg_q(cfg_q), .cfg_d(cfg_d), .cfg_r(cfg_r),
        .cfg_sets(cfg_sets), .xfer_done(xfer_done),
        .vec_req(vec_req), .rsp_req(rsp_req),
        .core_idx(core_idx), .pkt_num(pkt_num), .done(done)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference slot list built from the requirements.
    task automatic build(input int k, input int q, input int d, input int r, input int sets);
        int nr;
        exp_core.delete(); exp_pkt.delete(); exp_tag.delete();
        nr = (r == 0) ? 0 : (d * k) / r;
        if (k == 0) return;
        for (int s = 0; s < sets; s++) begin
            int ptr = 0;
            int pass = 0;
            for (int row = 1; row <= 2 * k; row++) begin
                for (int i = 0; i < q; i++) begin
                    exp_core.push_back(i); exp_pkt.push_back(row); exp_tag.push_back("R3/R5");
                end
                if (row % 2 == 1) begin
                    for (int i = 0; i < d; i++) begin
                        exp_core.push_back(q + k + ptr); exp_pkt.push_back(pass + 1);
                        exp_tag.push_back("R6");
                        ptr++;
                        if (ptr == nr) begin ptr = 0; pass++; end
                    end
                end else begin
                    exp_core.push_back(q + row / 2 - 1); exp_pkt.push_back(1);
                    exp_tag.push_back("R4/R7");
                end
            end
        end
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic run(input int k, input int q, input int d, input int r, input int sets,
                       input bit disturb, input string rtag);
        build(k, q, d, r, sets);
        @(negedge clk);
        cfg_k = CW'(k); cfg_q = CW'(q); cfg_d = CW'(d); cfg_r = CW'(r); cfg_sets = SETW'(sets);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (exp_core.size() == 0) begin
            check(done == 1'b1 && vec_req == 1'b0, {"R9 empty config done ", rtag}, done, 1);
            return;
        end
        foreach (exp_core[n]) begin
            int wait_cyc = 0;
            string tg = {exp_tag[n], " ", rtag};
            while (!vec_req && wait_cyc < 20) begin @(negedge clk); wait_cyc++; end
            check(wait_cyc == 0, {"R2 vec_req immediately ", tg}, wait_cyc, 0);
            check(int'(core_idx) == exp_core[n], {"core_idx ", tg}, core_idx, exp_core[n]);
            check(int'(pkt_num) == exp_pkt[n], {"pkt_num ", tg}, pkt_num, exp_pkt[n]);
            if (disturb && n == 2) begin
                // R10 R12: mid-run start with altered configuration
                cfg_k = CW'($urandom % 16); cfg_q = CW'($urandom % 16);
                cfg_d = CW'($urandom % 16); cfg_sets = SETW'(1);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check(vec_req == 1'b1 && int'(core_idx) == exp_core[n], "R10 slot kept after start",
                      core_idx, exp_core[n]);
            end
            repeat ($urandom % 3) @(negedge clk);
            pulse_done();
            check(rsp_req == 1'b1 && vec_req == 1'b0, {"R2 rsp phase ", tg}, rsp_req, 1);
            check(int'(core_idx) == exp_core[n], {"R2 rsp core ", tg}, core_idx, exp_core[n]);
            repeat ($urandom % 3) @(negedge clk);
            check(rsp_req == 1'b1, {"R2 rsp held ", tg}, rsp_req, 1);
            pulse_done();
        end
        check(done == 1'b1 && rsp_req == 1'b0, {"R8 done after sets ", rtag}, done, 1);
        repeat (3) @(negedge clk);
        check(done == 1'b1 && vec_req == 1'b0, {"R8 stays done ", rtag}, vec_req, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        check(vec_req == 0 && rsp_req == 0 && done == 0, "R1 reset requests", vec_req, 0);
        check(core_idx == 0 && pkt_num == 0, "R1 reset slot", core_idx, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(vec_req == 0 && done == 0, "R1 after reset", done, 0);

        run(2, 1, 1, 2, 2, 1'b0, "base");
        run(3, 2, 2, 3, 1, 1'b1, "R12 three-core");
        run(1, 0, 0, 1, 3, 1'b0, "R11");
        run(2, 0, 0, 5, 1, 1'b0, "R11 two");
        run(0, 2, 1, 1, 2, 1'b0, "R9 k0");
        run(2, 1, 1, 1, 0, 1'b0, "R9 sets0");
        run(2, 2, 3, 6, 2, 1'b1, "R10 one r core");

        for (int t = 0; t < 6; t++) begin
            int k = 1 + $urandom % 3;
            int q = $urandom % 3;
            int d = $urandom % 3;
            int r = 1;
            int dk = d * k;
            if (dk > 0) begin
                r = 1 + $urandom % dk;
                while (dk % r != 0) r = 1 + $urandom % dk;
            end else begin
                r = 1 + $urandom % 3;
            end
            run(k, q, d, r, 1 + $urandom % 2, t[0], "R8 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule